// File: doc/BRIEF.md
# Protection-Aware Image Checksum Engine

This block computes the 16-bit verification checksum of a programmed device image by reading that image through a synchronous memory read port. After a start request it first fetches the configuration word. The code-protect bit in that word selects one of two formulas. With protection off, the engine walks every program word from address 0 up to the last implemented word and adds each one to the masked configuration word. With protection on, it skips program memory completely. It reads the four identification words instead and adds a packed value made from their low nibbles.

The read port has one cycle of latency: the data for an address issued in one cycle is taken in the next. The total wraps modulo 2^16. When the sum is complete, a one-cycle done pulse marks the result, and the result stays unchanged until the next accepted start. The number of program words is a parameter, 1024 or 2048.

Top module: `ck_sum_engine`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, busy_o, done_o and rd_en_o are 0 and result_o is 0x0000.
- R2: A start_i sampled high while idle is accepted. In the following cycle the engine issues a read at address 0x2007, where the configuration word sits.
- R3: When bit 13 of the configuration word is 1 (unprotected), the engine reads program addresses 0 to PROG_WORDS-1, each exactly once and in ascending order. The result is the sum of those words plus (configuration word AND 0x3FFF).
- R4: When bit 13 of the configuration word is 0 (protected), the engine issues no read below 0x2000. It reads the identification words at 0x2000, 0x2001, 0x2002 and 0x2003, and the result is (configuration word AND 0x3FFF) plus the packed ID value.
- R5: The packed ID value uses only bits 3:0 of each identification word. The word at 0x2000 fills bits 15:12, 0x2001 fills 11:8, 0x2002 fills 7:4 and 0x2003 fills 3:0. Bits 13:4 of the ID words have no effect.
- R6: Only the low 16 bits of the total are kept, and every carry out of bit 15 is dropped.
- R7: done_o is high for exactly one cycle per computation. result_o already holds the final sum in that cycle and keeps it until the next accepted start.
- R8: A start_i that arrives while a computation is in progress is ignored. The computation runs to completion without restarting and produces one done pulse.
- R9: With every word erased to 0x3FFF, the result is 0x37FF when PROG_WORDS is 2048 and 0x3BFF when it is 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a checksum, taken only when idle |
| rd_data_i | input | 14 | Read data, valid one cycle after the request |
| busy_o | output | 1 | High from the cycle after acceptance through the done cycle |
| done_o | output | 1 | One-cycle pulse when result_o is final |
| rd_en_o | output | 1 | Read request to the image memory |
| rd_addr_o | output | 14 | Read address |
| result_o | output | 16 | Checksum, held after completion |

## Verification
The hardest case to reach from the ports is an accumulated total that overflows 16 bits. The bench reaches it in two ways. A full-size unprotected walk over a pattern whose true total far exceeds 65535. A protected image whose masked configuration word and packed IDs together pass 0xFFFF. A second case is a start request arriving in the middle of a long program walk. The bench pulses start_i deep inside the walk and then counts program reads and done pulses, so a restart would show up. A memory model counts program-region reads and flags any out-of-order address. This exposes the protected-path skip directly at the read port.

// File: rtl/cksum_pkg.sv
package cksum_pkg;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_CFG  = 2'd1,
    K_PROG = 2'd2,
    K_ID   = 2'd3
  } word_kind_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CFG   = 3'd1,
    S_CFGW  = 3'd2,
    S_PROG  = 3'd3,
    S_IDS   = 3'd4,
    S_DRAIN = 3'd5,
    S_DONE  = 3'd6
  } seq_state_e;

  localparam logic [13:0] CFG_WORD_ADDR = 14'h2007;
  localparam logic [13:0] ID_BASE_ADDR  = 14'h2000;
  localparam int          PROT_BIT      = 13;

  // configuration contribution: word masked to 14 bits
  function automatic logic [15:0] cfg_term(input logic [15:0] w);
    return w & 16'h3FFF;
  endfunction

  // identification contribution: low nibble placed by index, index 0 highest
  function automatic logic [15:0] id_term(input logic [15:0] w, input logic [1:0] idx);
    logic [4:0] sh;
    sh = {~idx, 2'b00};
    return {12'h000, w[3:0]} << sh;
  endfunction

  function automatic logic [15:0] wrap_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[15:0];
  endfunction

endpackage

// File: rtl/ck_addr_seq.sv
module ck_addr_seq
  import cksum_pkg::*;
#(
  parameter  int PROG_WORDS = 2048,
  parameter  int ADDR_W     = 14,
  localparam int CNT_W      = $clog2(PROG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              prot_bit_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output word_kind_e        kind_q_o,
  output logic [1:0]        idx_q_o,
  output logic              accept_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              prot_mode_o,
  output logic              prog_phase_o
);

  localparam logic [CNT_W-1:0] LAST_PROG = CNT_W'(PROG_WORDS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  word_kind_e       kind_now;
  logic             prot_q;
  logic             last_prog, last_id;

  assign accept_o  = (state_q == S_IDLE) && start_i;
  assign last_prog = (cnt_q == LAST_PROG);
  assign last_id   = (cnt_q[1:0] == 2'd3);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = S_CFG;
      S_CFG:   state_d = S_CFGW;
      S_CFGW: begin
        cnt_d   = '0;
        state_d = prot_bit_i ? S_PROG : S_IDS;
      end
      S_PROG: begin
        cnt_d = cnt_q + 1'b1;
        if (last_prog) state_d = S_DRAIN;
      end
      S_IDS: begin
        cnt_d = cnt_q + 1'b1;
        if (last_id) state_d = S_DRAIN;
      end
      S_DRAIN: state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    kind_now  = K_NONE;
    rd_addr_o = '0;
    unique case (state_q)
      S_CFG: begin
        kind_now  = K_CFG;
        rd_addr_o = ADDR_W'(CFG_WORD_ADDR);
      end
      S_PROG: begin
        kind_now  = K_PROG;
        rd_addr_o = ADDR_W'(cnt_q);
      end
      S_IDS: begin
        kind_now  = K_ID;
        rd_addr_o = ADDR_W'(ID_BASE_ADDR) | ADDR_W'(cnt_q[1:0]);
      end
      default: ;
    endcase
  end

  assign rd_en_o = (kind_now != K_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      kind_q_o <= K_NONE;
      idx_q_o  <= '0;
      prot_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      kind_q_o <= kind_now;
      idx_q_o  <= cnt_q[1:0];
      if (state_q == S_CFGW) prot_q <= ~prot_bit_i;
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_DONE);
  assign prot_mode_o  = prot_q;
  assign prog_phase_o = (state_q == S_PROG);

endmodule

// File: rtl/ck_accum.sv
module ck_accum
  import cksum_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  word_kind_e  kind_i,
  input  logic [1:0]  idx_i,
  input  logic [15:0] data_i,
  output logic [15:0] sum_o
);

  logic [15:0] term;

  always_comb begin
    unique case (kind_i)
      K_CFG:   term = cfg_term(data_i);
      K_PROG:  term = data_i;
      K_ID:    term = id_term(data_i, idx_i);
      default: term = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                sum_o <= 16'h0000;
    else if (clear_i)          sum_o <= 16'h0000;
    else if (kind_i != K_NONE) sum_o <= wrap_add(sum_o, term);
  end

endmodule

// File: rtl/ck_sum_engine.sv
module ck_sum_engine
  import cksum_pkg::*;
#(
  parameter int PROG_WORDS = 2048,
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [15:0]       result_o
);

  word_kind_e  kind_q;
  logic [1:0]  idx_q;
  logic        accept_start;
  logic        prot_mode;
  logic        prog_phase;
  logic [15:0] data_ext;

  assign data_ext = 16'(rd_data_i);

  ck_addr_seq #(
    .PROG_WORDS (PROG_WORDS),
    .ADDR_W     (ADDR_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .prot_bit_i   (rd_data_i[PROT_BIT]),
    .rd_en_o      (rd_en_o),
    .rd_addr_o    (rd_addr_o),
    .kind_q_o     (kind_q),
    .idx_q_o      (idx_q),
    .accept_o     (accept_start),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .prot_mode_o  (prot_mode),
    .prog_phase_o (prog_phase)
  );

  ck_accum u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept_start),
    .kind_i  (kind_q),
    .idx_i   (idx_q),
    .data_i  (data_ext),
    .sum_o   (result_o)
  );

endmodule

// File: rtl/ck_sum_engine_chk.sv
module ck_sum_engine_chk #(
  parameter int PROG_WORDS = 2048,
  parameter int ADDR_W     = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [15:0]       result_o,
  input logic              accept_start,
  input logic              prot_mode,
  input logic              prog_phase
);

  // R2
  cfg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> (rd_en_o && rd_addr_o == ADDR_W'(14'h2007)));

  // R3
  prog_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && prog_phase) |-> (rd_addr_o < ADDR_W'(PROG_WORDS)));

  // R3
  prog_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && prog_phase && $past(rd_en_o && prog_phase))
      |-> (rd_addr_o == $past(rd_addr_o) + 1'b1));

  // R4
  prot_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && prot_mode) |-> rd_addr_o[ADDR_W-1]);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(result_o));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

endmodule

bind ck_sum_engine ck_sum_engine_chk #(
  .PROG_WORDS (PROG_WORDS),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .rd_en_o      (rd_en_o),
  .rd_addr_o    (rd_addr_o),
  .result_o     (result_o),
  .accept_start (accept_start),
  .prot_mode    (prot_mode),
  .prog_phase   (prog_phase)
);

// File: tb/ck_mem_model.sv
module ck_mem_model #(
  parameter int WORDS = 2048
) (
  input  logic        clk,
  input  logic        clr,
  input  logic        en,
  input  logic [13:0] addr,
  output logic [13:0] dout,
  output int          prog_reads,
  output int          order_errs
);

  logic [13:0] prog [WORDS];
  logic [13:0] cfg;
  logic [13:0] ids [4];
  logic [13:0] last_addr;
  logic        seen;

  always @(posedge clk) begin
    if (clr) begin
      prog_reads <= 0;
      order_errs <= 0;
      seen       <= 1'b0;
      last_addr  <= '0;
    end else if (en) begin
      if (addr[13]) begin
        if (addr == 14'h2007)      dout <= cfg;
        else if (addr[12:2] == '0) dout <= ids[addr[1:0]];
        else                       dout <= '0;
      end else begin
        prog_reads <= prog_reads + 1;
        seen       <= 1'b1;
        last_addr  <= addr;
        if (int'(addr) < WORDS) dout <= prog[int'(addr)];
        else                    dout <= '0;
        if ((int'(addr) >= WORDS) || (seen ? (addr != last_addr + 14'd1) : (addr != 14'd0)))
          order_errs <= order_errs + 1;
      end
    end
  end

endmodule

// File: tb/test_ck_sum_engine.sv
module test_ck_sum_engine;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start, start_s;
  logic        clr, clr_s;
  logic [13:0] rdata, rdata_s;
  logic        busy, done, rd_en, busy_s, done_s, rd_en_s;
  logic [13:0] raddr, raddr_s;
  logic [15:0] result, result_s;
  int          preads, oerrs, preads_s, oerrs_s;

  int checks = 0;
  int fails  = 0;

  ck_sum_engine #(.PROG_WORDS(2048)) i_ck_sum_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rd_data_i(rdata),
    .busy_o(busy), .done_o(done), .rd_en_o(rd_en), .rd_addr_o(raddr), .result_o(result));

  ck_mem_model #(.WORDS(2048)) i_mem (
    .clk(clk), .clr(clr), .en(rd_en), .addr(raddr), .dout(rdata),
    .prog_reads(preads), .order_errs(oerrs));

  ck_sum_engine #(.PROG_WORDS(1024)) i_ck_sum_engine_1k (
    .clk(clk), .rst_n(rst_n), .start_i(start_s), .rd_data_i(rdata_s),
    .busy_o(busy_s), .done_o(done_s), .rd_en_o(rd_en_s), .rd_addr_o(raddr_s), .result_o(result_s));

  ck_mem_model #(.WORDS(1024)) i_mem_1k (
    .clk(clk), .clr(clr_s), .en(rd_en_s), .addr(raddr_s), .dout(rdata_s),
    .prog_reads(preads_s), .order_errs(oerrs_s));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // bench-side reference: plain integer total, reduced at the end
  function automatic int ref_unprot(input int n);
    int acc = 0;
    for (int k = 0; k < n; k++) acc += int'(i_mem.prog[k]);
    acc += int'(i_mem.cfg) % 16384;
    return acc;
  endfunction

  function automatic int ref_prot();
    int packed_ids = 0;
    for (int k = 0; k < 4; k++) packed_ids = packed_ids * 16 + (int'(i_mem.ids[k]) % 16);
    return (int'(i_mem.cfg) % 16384) + packed_ids;
  endfunction

  // run the 2K engine; mid>0 pulses start that many cycles into the run
  task automatic run_main(input int mid, output logic [15:0] res, output int dones);
    int waited = 0;
    dones = 0;
    @(negedge clk) clr = 1'b1;
    @(negedge clk) begin clr = 1'b0; start = 1'b1; end
    @(negedge clk) start = 1'b0;
    while (waited < 5000) begin
      if (mid > 0 && waited == mid) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      waited++;
      if (done) begin dones++; res = result; break; end
    end
    start = 1'b0;
    if (waited >= 5000) chk(1'b0, "R7 done timeout", waited, 0);
    // watch for any extra pulse
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done) dones++;
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !rd_en, "R1 idle controls", {busy, done, rd_en}, 0);
    chk(result == 16'h0, "R1 result", result, 0);
  endtask

  task automatic t_latency();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) begin clr = 1'b0; start = 1'b1; end
    @(negedge clk) start = 1'b0;
    chk(rd_en && raddr == 14'h2007, "R2 config read first", raddr, 14'h2007);
    wait (done == 1'b0 && busy == 1'b0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_blank2k();
    logic [15:0] r; int d;
    for (int k = 0; k < 2048; k++) i_mem.prog[k] = 14'h3FFF;
    i_mem.cfg = 14'h3FFF;
    run_main(0, r, d);
    chk(r == 16'h37FF, "R9 blank 2K", r, 16'h37FF);
    chk(preads == 2048 && oerrs == 0, "R3 walk count/order", preads, 2048);
  endtask

  task automatic t_blank1k();
    int waited = 0;
    for (int k = 0; k < 1024; k++) i_mem_1k.prog[k] = 14'h3FFF;
    i_mem_1k.cfg = 14'h3FFF;
    @(negedge clk) clr_s = 1'b1;
    @(negedge clk) begin clr_s = 1'b0; start_s = 1'b1; end
    @(negedge clk) start_s = 1'b0;
    while (!done_s && waited < 3000) begin @(negedge clk); waited++; end
    chk(result_s == 16'h3BFF, "R9 blank 1K", result_s, 16'h3BFF);
    chk(preads_s == 1024 && oerrs_s == 0, "R3 1K walk count/order", preads_s, 1024);
  endtask

  task automatic t_pattern();
    logic [15:0] r; int d; int e;
    for (int k = 0; k < 2048; k++) i_mem.prog[k] = 14'((k * 37 + 11) ^ (k << 5));
    i_mem.cfg = 14'h3F4A;
    e = ref_unprot(2048);
    run_main(0, r, d);
    // R6: true total is far above 16 bits here
    chk(e > 65535, "R6 pattern overflows", e, 65536);
    chk(r == 16'(e), "R3 R6 pattern sum", r, e % 65536);
    chk(d == 1, "R7 single done", d, 1);
    chk(oerrs == 0, "R3 pattern order", oerrs, 0);
  endtask

  task automatic t_protected();
    logic [15:0] r; int d; int e;
    i_mem.cfg = 14'h1F3C;
    i_mem.ids[0] = 14'h3FF1; i_mem.ids[1] = 14'h0002;
    i_mem.ids[2] = 14'h3FA3; i_mem.ids[3] = 14'h0014;
    e = ref_prot();
    run_main(0, r, d);
    chk(e == 16'h3170, "R5 bench packing", e, 16'h3170);
    chk(r == 16'h3170, "R4 R5 protected sum", r, 16'h3170);
    chk(preads == 0, "R4 no program reads", preads, 0);
  endtask

  task automatic t_prot_carry();
    logic [15:0] r; int d;
    i_mem.cfg = 14'h1FFF;
    for (int k = 0; k < 4; k++) i_mem.ids[k] = 14'h000F;
    run_main(0, r, d);
    chk(r == 16'h1FFE, "R6 protected carry dropped", r, 16'h1FFE);
  endtask

  task automatic t_busy_start();
    logic [15:0] r; int d; int e;
    for (int k = 0; k < 2048; k++) i_mem.prog[k] = 14'(k);
    i_mem.cfg = 14'h2001;
    e = ref_unprot(2048);
    run_main(700, r, d);
    chk(d == 1, "R8 one done despite restart request", d, 1);
    chk(preads == 2048 && oerrs == 0, "R8 walk not restarted", preads, 2048);
    chk(r == 16'(e), "R8 sum unaffected", r, e % 65536);
  endtask

  task automatic t_hold();
    logic [15:0] r; int d;
    logic [15:0] first;
    i_mem.cfg = 14'h0ABC;
    for (int k = 0; k < 4; k++) i_mem.ids[k] = 14'(k + 5);
    run_main(0, r, d);
    first = result;
    chk(first == r, "R7 result held after done", first, r);
    chk(!done, "R7 done low after pulse", done, 0);
    repeat (5) @(negedge clk);
    chk(result == r, "R7 result stable idle", result, r);
  endtask

  initial begin
    start = 1'b0; start_s = 1'b0; clr = 1'b0; clr_s = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    i_mem.cfg = 14'h3FFF;
    for (int k = 0; k < 2048; k++) i_mem.prog[k] = 14'h0;
    t_latency();
    t_blank2k();
    t_blank1k();
    t_pattern();
    t_protected();
    t_prot_carry();
    t_busy_start();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule